// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits beside a small processor core and arbitrates 32 interrupt request lines. A rising level on a line is latched as a pending request. Each line has its own enable bit and a 3-bit priority, where a lower value is more urgent. Among the pending, enabled lines the block picks a winner and presents its source number and handler address to the core. The handler address is a programmable base plus four times the source number, so the core can branch to the handler without asking which line fired.

Software sets a split value M, which marks the low M bits of each priority as subpriority; the remaining high bits form the preemption group. A request interrupts the running handler only when its group is strictly more urgent. Requests in the same group wait and are handed over back-to-back when the running handler returns. A stack of eight preemption levels follows the nesting. A global mask holds off delivery without changing any enable bit.

The core accepts the presented request with `take_i` and ends a handler with `ret_i`. After the last handler returns, and when no deliverable request remains, the block pulses `ctx_exit_o` so that the core leaves interrupt context.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A line becomes pending on a 0-to-1 transition of `irq_i`. A line held high after its request is taken does not become pending again.
- R2: A pending line whose enable bit is 0 produces no request. Setting its enable later delivers the request that is still pending. Register address 0 writes the enable vector, with bit i for line i.
- R3: When the global mask bit is set, `irq_req_o` stays low, and the enable bits are unchanged. Clearing the mask delivers the still-pending requests again. Register address 2, bit 0, holds the mask, where 1 means masked.
- R4: Among pending, enabled lines, the lowest full priority value wins, and on equal values the lowest line number wins. Priorities are written at addresses 8 to 11. Address 8+k holds lines 8k to 8k+7, and line 8k+j uses bits [4j+2:4j].
- R5: While `irq_req_o` is high, `irq_id_o` gives the winning line and `irq_vec_o` equals the vector base plus 4 times that line number. The vector base is written at address 4.
- R6: With split M (address 3, bits [1:0]), the group is the priority with its low M bits cleared. A request preempts an active handler only if its group is numerically lower than the level of the running handler.
- R7: A request in the same group as the running handler is held back. When that handler returns to depth 0, the request is offered next, and no exit pulse is given.
- R8: A take while `irq_req_o` is high clears that line's pending bit, pushes its group onto the level stack, and sets `in_ctx_o`. The depth never exceeds 8.
- R9: A return pops the stack, so preemption is judged against the previous nested handler's level again.
- R10: `ctx_exit_o` pulses for one cycle after the return that empties the stack, but only if no enabled, unmasked request is pending at that moment.
- R11: Writing 1s to address 1 clears the matching pending bits without servicing them.
- R12: `irq_req_o` is low in the cycle after an accepted take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 32 | Interrupt request levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| take_i | input | 1 | Core accepts the presented request |
| ret_i | input | 1 | Core returns from the current handler |
| irq_req_o | output | 1 | A request is offered to the core |
| irq_id_o | output | 5 | Winning line number |
| irq_vec_o | output | 32 | Handler address of the winning line |
| in_ctx_o | output | 1 | At least one handler is active |
| ctx_exit_o | output | 1 | One-cycle pulse: leave interrupt context |

## Verification
A corrupted pending or enable bit shows up at the ports within two cycles of the edge that caused it: either a wrong `irq_id_o` or a missing or extra `irq_req_o`. A wrong entry on the level stack stays hidden until a request arrives that falls between the true level and the stored one. At that point the request either preempts when it should not, or is held back when it should preempt, so the bench nests handlers and then probes with priorities on both sides of the restored level. A wrong depth count shows up at the final return, as a missing or early `ctx_exit_o`.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int ADDR_W  = 4;
  localparam int FIELD_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_ENABLE = 4'd0,
    A_PCLR   = 4'd1,
    A_GMASK  = 4'd2,
    A_SPLIT  = 4'd3,
    A_VBASE  = 4'd4
  } pic_addr_e;

  localparam logic [ADDR_W-1:0] A_PRIO0 = 4'd8;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32,
  parameter int SPLIT_W = 2,
  parameter int ID_W    = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NSRC-1:0]               irq_i,
  input  logic                          cfg_we,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [DATA_W-1:0]             cfg_wdata,
  input  logic                          clr_valid,
  input  logic [ID_W-1:0]               clr_id,
  output logic [NSRC-1:0]               en_o,
  output logic [NSRC-1:0]               pend_o,
  output logic [NSRC-1:0][PRIO_W-1:0]   prio_o,
  output logic                          gmask_o,
  output logic [SPLIT_W-1:0]            split_o,
  output logic [DATA_W-1:0]             vbase_o
);
  localparam int PER_WORD = DATA_W / FIELD_W;

  logic [NSRC-1:0] irq_q;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] wr_clr;
  logic [NSRC-1:0] tk_clr;

  assign rise   = irq_i & ~irq_q;
  assign wr_clr = (cfg_we && cfg_addr == A_PCLR) ? cfg_wdata[NSRC-1:0] : '0;
  assign tk_clr = clr_valid ? (NSRC'(1) << clr_id) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= '0;
      pend_o  <= '0;
      en_o    <= '0;
      gmask_o <= 1'b0;
      split_o <= '0;
      vbase_o <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_o <= (pend_o & ~(wr_clr | tk_clr)) | rise;
      if (cfg_we) begin
        case (cfg_addr)
          A_ENABLE: en_o    <= cfg_wdata[NSRC-1:0];
          A_GMASK:  gmask_o <= cfg_wdata[0];
          A_SPLIT:  split_o <= cfg_wdata[SPLIT_W-1:0];
          A_VBASE:  vbase_o <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_prio
    localparam int WORD = i / PER_WORD;
    localparam int FLD  = i % PER_WORD;
    always_ff @(posedge clk) begin
      if (rst) begin
        prio_o[i] <= '0;
      end else if (cfg_we && cfg_addr == ADDR_W'(int'(A_PRIO0) + WORD)) begin
        prio_o[i] <= cfg_wdata[FLD*FIELD_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic [NSRC-1:0]             cand,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  output logic                        valid,
  output logic [ID_W-1:0]             id,
  output logic [PRIO_W-1:0]           best
);
  always_comb begin
    valid = 1'b0;
    id    = '0;
    best  = '1;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i] && (!valid || prio[i] <= best)) begin
        valid = 1'b1;
        id    = ID_W'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/pic_stack.sv
module pic_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_lvl,
  output logic [CNT_W-1:0]  depth_o,
  output logic [PRIO_W-1:0] top_o,
  output logic              full_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] mem [DEPTH];

  assign full_o = (depth_o == CNT_W'(DEPTH));
  assign top_o  = (depth_o == '0) ? '1 : mem[IDX_W'(depth_o - CNT_W'(1))];

  always_ff @(posedge clk) begin
    if (push && !full_o) mem[IDX_W'(depth_o)] <= push_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) depth_o <= '0;
    else if (push && !full_o) depth_o <= depth_o + CNT_W'(1);
    else if (pop && depth_o != '0) depth_o <= depth_o - CNT_W'(1);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NSRC-1:0]           irq_i,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [DATA_W-1:0]         cfg_wdata,
  input  logic                      take_i,
  input  logic                      ret_i,
  output logic                      irq_req_o,
  output logic [$clog2(NSRC)-1:0]   irq_id_o,
  output logic [DATA_W-1:0]         irq_vec_o,
  output logic                      in_ctx_o,
  output logic                      ctx_exit_o
);
  localparam int ID_W    = $clog2(NSRC);
  localparam int SPLIT_W = $clog2(PRIO_W + 1);
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic [NSRC-1:0]             en, pend;
  logic [NSRC-1:0][PRIO_W-1:0] prio;
  logic                        gmask;
  logic [SPLIT_W-1:0]          split;
  logic [DATA_W-1:0]           vbase;
  logic                        best_valid;
  logic [ID_W-1:0]             best_id;
  logic [PRIO_W-1:0]           best_prio;
  logic [PRIO_W-1:0]           lowmask;
  logic [PRIO_W-1:0]           best_grp;
  logic [CNT_W-1:0]            depth;
  logic [PRIO_W-1:0]           top_lvl;
  logic                        full;
  logic                        may_go, deliverable;
  logic                        take_acc, ret_acc;
  logic                        req_q, exit_q;
  logic [ID_W-1:0]             id_q;
  logic [PRIO_W-1:0]           lvl_q;
  logic [DATA_W-1:0]           vec_q;

  pic_regs #(
    .NSRC(NSRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .SPLIT_W(SPLIT_W), .ID_W(ID_W)
  ) u_regs (
    .clk(clk), .rst(rst), .irq_i(irq_i),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .clr_valid(take_acc), .clr_id(id_q),
    .en_o(en), .pend_o(pend), .prio_o(prio),
    .gmask_o(gmask), .split_o(split), .vbase_o(vbase)
  );

  pic_arbiter #(
    .NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
  ) u_arb (
    .cand(pend & en), .prio(prio),
    .valid(best_valid), .id(best_id), .best(best_prio)
  );

  always_comb begin
    for (int b = 0; b < PRIO_W; b++) lowmask[b] = (b < int'(split));
  end

  assign best_grp    = best_prio & ~lowmask;
  assign deliverable = best_valid && !gmask;
  assign may_go      = deliverable && !full && (depth == '0 || best_grp < top_lvl);
  assign ret_acc     = ret_i && depth != '0;
  assign take_acc    = take_i && req_q && !ret_i;

  pic_stack #(
    .DEPTH(DEPTH), .PRIO_W(PRIO_W), .CNT_W(CNT_W)
  ) u_stk (
    .clk(clk), .rst(rst),
    .push(take_acc), .pop(ret_acc), .push_lvl(lvl_q & ~lowmask),
    .depth_o(depth), .top_o(top_lvl), .full_o(full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      exit_q <= 1'b0;
      id_q   <= '0;
      lvl_q  <= '0;
      vec_q  <= '0;
    end else begin
      req_q  <= may_go && !take_acc;
      exit_q <= ret_acc && depth == CNT_W'(1) && !deliverable;
      id_q   <= best_id;
      lvl_q  <= best_prio;
      vec_q  <= vbase + (DATA_W'(best_id) << 2);
    end
  end

  assign irq_req_o  = req_q;
  assign irq_id_o   = id_q;
  assign irq_vec_o  = vec_q;
  assign ctx_exit_o = exit_q;
  assign in_ctx_o   = (depth != '0);
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = 5,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              take,
  input logic              ret,
  input logic [CNT_W-1:0]  depth,
  input logic              ex,
  input logic              gmask,
  input logic [DATA_W-1:0] vbase,
  input logic [ID_W-1:0]   id,
  input logic [DATA_W-1:0] vec
);
  p_mask_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    req |-> !$past(gmask));

  p_vec_calc_r5: assert property (@(posedge clk) disable iff (rst)
    req |-> vec == $past(vbase) + DATA_W'({id, 2'b00}));

  p_depth_cap_r8: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(DEPTH));

  p_push_r8: assert property (@(posedge clk) disable iff (rst)
    (req && take && !ret && depth < CNT_W'(DEPTH)) |=> depth == $past(depth) + CNT_W'(1));

  p_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (ret && depth != '0) |=> depth == $past(depth) - CNT_W'(1));

  p_exit_single_r10: assert property (@(posedge clk) disable iff (rst)
    ex |=> !ex);

  p_exit_idle_r10: assert property (@(posedge clk) disable iff (rst)
    ex |-> depth == '0);

  p_req_drop_r12: assert property (@(posedge clk) disable iff (rst)
    (req && take && !ret) |=> !req);
endmodule

bind prio_irq_ctrl pic_checker #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .ID_W(ID_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .req(irq_req_o), .take(take_i), .ret(ret_i),
  .depth(depth), .ex(ctx_exit_o), .gmask(gmask), .vbase(vbase),
  .id(irq_id_o), .vec(irq_vec_o)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        take = 1'b0, ret = 1'b0;
  logic        req, in_ctx, ex;
  logic [4:0]  id;
  logic [31:0] vec;

  int total = 0;
  int bad = 0;
  logic [31:0] m_en = '0;
  logic [31:0] m_base = '0;
  logic [2:0]  m_prio [32];

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_i(irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .take_i(take), .ret_i(ret), .irq_req_o(req),
    .irq_id_o(id), .irq_vec_o(vec), .in_ctx_o(in_ctx), .ctx_exit_o(ex)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_en(input logic [31:0] e);
    m_en = e;
    wr(4'd0, e);
  endtask

  task automatic set_prio(input int i, input logic [2:0] p);
    logic [31:0] w;
    m_prio[i] = p;
    w = '0;
    for (int j = 0; j < 8; j++) w[j*4 +: 3] = m_prio[(i/8)*8 + j];
    wr(4'(8 + i/8), w);
  endtask

  task automatic raise(input int i);
    @(negedge clk);
    irq[i] = 1'b1;
  endtask

  task automatic do_take();
    @(negedge clk);
    take = 1'b1;
    @(negedge clk);
    take = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk);
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
  endtask

  function automatic int winner(input logic [31:0] cand);
    int w = -1;
    for (int i = 0; i < 32; i++)
      if (cand[i] && (w < 0 || m_prio[i] < m_prio[w])) w = i;
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) m_prio[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset req", 32'(req), 0);
    chk("R8 reset in_ctx", 32'(in_ctx), 0);
    chk("R10 reset exit", 32'(ex), 0);

    // R4 R5 tie and vector, R7 tail chain
    m_base = 32'h1000;
    wr(4'd4, m_base);
    set_en('1);
    for (int i = 0; i < 32; i++) set_prio(i, 3'd3);
    @(negedge clk); irq[7] = 1'b1; irq[3] = 1'b1;
    settle();
    chk("R4 tie req", 32'(req), 1);
    chk("R4 tie id", 32'(id), 3);
    chk("R5 vec", vec, 32'h100C);
    do_take();
    chk("R12 req drop", 32'(req), 0);
    chk("R8 in_ctx", 32'(in_ctx), 1);
    settle();
    chk("R6 equal no preempt", 32'(req), 0);
    do_ret();
    chk("R7 no exit on chain", 32'(ex), 0);
    settle();
    chk("R7 chain req", 32'(req), 1);
    chk("R7 chain id", 32'(id), 7);
    do_take(); do_ret();
    chk("R10 exit pulse", 32'(ex), 1);
    @(negedge clk);
    chk("R10 exit one cycle", 32'(ex), 0);
    irq = '0; settle();

    // R9 nesting and pop
    set_prio(5, 3'd4); set_prio(9, 3'd1); set_prio(12, 3'd5); set_prio(2, 3'd2);
    raise(5); settle(); do_take();
    raise(9); settle();
    chk("R6 preempt id", 32'(id), 9);
    do_take();
    do_ret();
    raise(12); settle();
    chk("R9 lower blocked", 32'(req), 0);
    raise(2); settle();
    chk("R9 restored level preempt", 32'(id), 2);
    chk("R9 restored level req", 32'(req), 1);
    do_take(); do_ret();
    chk("R10 no exit nested", 32'(ex), 0);
    do_ret();
    chk("R7 no exit pending", 32'(ex), 0);
    settle();
    chk("R7 chain after nest", 32'(id), 12);
    do_take(); do_ret();
    chk("R10 exit after nest", 32'(ex), 1);
    irq = '0; settle();

    // R6 subpriority split M=2
    wr(4'd3, 32'd2);
    set_prio(4, 3'd5); set_prio(6, 3'd4); set_prio(8, 3'd1);
    set_prio(10, 3'd3); set_prio(11, 3'd2);
    @(negedge clk); irq[10] = 1'b1; irq[11] = 1'b1;
    settle();
    chk("R4 subprio order", 32'(id), 11);
    do_take(); settle();
    chk("R7 same group held", 32'(req), 0);
    do_ret();
    chk("R7 chain no exit", 32'(ex), 0);
    settle();
    chk("R7 chain sub id", 32'(id), 10);
    do_take(); do_ret();
    chk("R10 exit sub", 32'(ex), 1);
    raise(4); settle(); do_take();
    raise(6); settle();
    chk("R6 same group blocked", 32'(req), 0);
    raise(8); settle();
    chk("R6 group preempt req", 32'(req), 1);
    chk("R6 group preempt id", 32'(id), 8);
    do_take(); do_ret(); settle();
    chk("R9 back to group", 32'(req), 0);
    do_ret();
    chk("R7 exit held", 32'(ex), 0);
    settle();
    chk("R7 chain grp id", 32'(id), 6);
    do_take(); do_ret();
    chk("R10 exit grp", 32'(ex), 1);
    wr(4'd3, 32'd0);
    irq = '0; settle();

    // R3 global mask
    set_prio(13, 3'd0);
    wr(4'd2, 32'd1);
    raise(13); settle();
    chk("R3 masked", 32'(req), 0);
    wr(4'd2, 32'd0); settle();
    chk("R3 unmasked req", 32'(req), 1);
    chk("R3 unmasked id", 32'(id), 13);
    do_take(); do_ret();
    irq = '0; settle();

    // R2 enable, R1 level, R11 pending clear
    set_prio(14, 3'd0);
    set_en(m_en & ~(32'd1 << 14));
    raise(14); settle();
    chk("R2 disabled", 32'(req), 0);
    set_en(m_en | (32'd1 << 14)); settle();
    chk("R2 enabled req", 32'(req), 1);
    chk("R2 enabled id", 32'(id), 14);
    do_take(); do_ret();
    chk("R10 exit level", 32'(ex), 1);
    settle();
    chk("R1 held level no repend", 32'(req), 0);
    @(negedge clk); irq[14] = 1'b0;
    set_en(m_en & ~(32'd1 << 14));
    raise(14); settle();
    wr(4'd1, 32'd1 << 14);
    set_en(m_en | (32'd1 << 14)); settle();
    chk("R11 cleared", 32'(req), 0);
    irq = '0; settle();

    // R8 full nesting depth
    for (int k = 0; k < 8; k++) set_prio(16 + k, 3'(7 - k));
    for (int k = 0; k < 8; k++) begin
      raise(16 + k); settle();
      chk("R8 nest id", 32'(id), 32'(16 + k));
      do_take();
    end
    chk("R8 deep in_ctx", 32'(in_ctx), 1);
    for (int k = 0; k < 8; k++) begin
      do_ret();
      chk("R10 exit only last", 32'(ex), 32'(k == 7));
    end
    chk("R9 stack empty", 32'(in_ctx), 0);
    irq = '0; settle();

    // random patterns, R4 R5
    for (int it = 0; it < 40; it++) begin
      logic [31:0] raised;
      int w;
      m_base = $urandom & 32'hFFFF_FF00;
      wr(4'd4, m_base);
      set_en($urandom);
      for (int i = 0; i < 32; i++) m_prio[i] = 3'($urandom);
      for (int i = 0; i < 32; i += 8) set_prio(i, m_prio[i]);
      raised = $urandom;
      @(negedge clk); irq = raised;
      settle();
      w = winner(raised & m_en);
      chk("R4 rand req", 32'(req), 32'(w >= 0));
      if (w >= 0) begin
        chk("R4 rand id", 32'(id), 32'(w));
        chk("R5 rand vec", vec, m_base + 32'(4 * w));
        do_take(); do_ret();
      end
      wr(4'd1, '1);
      @(negedge clk); irq = '0;
      settle();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule